// File: doc/BRIEF.md
# Per-Core Power and Reset Sequencer Register

This block is a 32-bit control register that holds one reset bit for each of four processor cores, plus other reset bits that it only stores. Software writes a full word. On each write the block compares the new value of each core bit with the value already held. A core whose bit does not change is left alone. A core whose bit rises to 1 is powered off. A core whose bit falls to 0 is powered back on and gets a start-with-reset pulse.

The block drives two outputs per core. `core_off` is a level that stays high while the core is held powered down. `core_start` is a single-cycle pulse that tells the core to come up out of reset. Some bit positions are reserved. Writes to them have no effect, and they always read back at their reset values. The written value is stored in the same clock edge that produces the side effects, so a read made after the write returns the new value.

Top module: `core_rst_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x00003d0f, `core_off` is 4'b1111 and `core_start` is 4'b0000.
- R2: Bits set in the reserved mask 0x0000c2f0 cannot be written. They always read back as the reset value masked with 0xc2f0, which is 0.
- R3: On a write, every non-reserved bit of `wr_data` is stored and appears on `rd_data` in the cycle after the write edge.
- R4: When the bit of core i (bit position i, for i = 0..3) changes from 0 to 1, `core_off[i]` goes high in the cycle after the write, and `core_start[i]` stays low.
- R5: When the bit of core i changes from 1 to 0, `core_off[i]` goes low and `core_start[i]` is high in the cycle after the write.
- R6: A core whose bit is written with the value it already holds gets no pulse, and its `core_off` level is unchanged.
- R7: Each core is handled on its own. In a single write, some cores can be powered off while others are started.
- R8: `core_start` is high for exactly one cycle per falling core bit. With no write, no pulse occurs and `core_off` holds.
- R9: Back-to-back writes on consecutive cycles are each applied in full, in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Value to write |
| rd_data | output | 32 | Stored register value |
| core_off | output | 4 | Per-core power-off level |
| core_start | output | 4 | Per-core one-cycle power-on-with-reset pulse |

## Verification
The case most likely to break is a single write that raises some core bits and clears others, so that one core is powered off in the same cycle another receives its start pulse. The bench provokes this by moving the core field from 0x5 to 0xA, and on consecutive cycles from 0xF to 0x0 and back. Each expected result is predicted per core from the previously stored value. The scoreboard then compares `rd_data`, `core_off` and `core_start` together in the cycle after each write edge, so an off level that leaks onto a starting core, or a pulse that lingers, shows up at once.

// File: rtl/core_rst_ctl.sv
module core_rst_ctl #(
  parameter int DATA_W = 32,
  parameter int NCORES = 4,
  parameter logic [DATA_W-1:0] RST_VALUE = 32'h0000_3d0f,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h0000_c2f0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCORES-1:0] core_off,
  output logic [NCORES-1:0] core_start
);

  localparam logic [DATA_W-1:0] KEEP = RST_VALUE & RSVD_MASK;

  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] next_val;
  logic [NCORES-1:0] old_bits, new_bits, flip;

  assign next_val = (wr_data & ~RSVD_MASK) | KEEP;
  assign old_bits = ctl_q[NCORES-1:0];
  assign new_bits = next_val[NCORES-1:0];
  assign flip     = old_bits ^ new_bits;
  assign rd_data  = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= RST_VALUE;
      core_off   <= RST_VALUE[NCORES-1:0];
      core_start <= '0;
    end else begin
      core_start <= wr_en ? (flip & ~new_bits) : '0;
      if (wr_en) begin
        ctl_q    <= next_val;
        core_off <= (core_off & ~flip) | (flip & new_bits);
      end
    end
  end

  AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD_MASK) == KEEP);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(core_off) && core_start == '0);  // R8

  for (genvar i = 0; i < NCORES; i++) begin : g_chk
    AST_OFF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_off[i]) |-> $past(wr_en) && $past(wr_data[i]));  // R4

    AST_START_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      core_start[i] |-> $past(wr_en) && $past(rd_data[i]) && !rd_data[i]);  // R5

    AST_START_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      core_start[i] |-> !core_off[i]);  // R7

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_start[i] && !wr_en |=> !core_start[i]);  // R8
  end

endmodule

// File: tb/tb_core_rst_ctl.sv
module tb_core_rst_ctl;
  localparam logic [31:0] RSTV = 32'h0000_3d0f;
  localparam logic [31:0] RSVD = 32'h0000_c2f0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  core_off, core_start;

  int total = 0;
  int bad = 0;
  logic [39:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_reg;
  logic [3:0]  m_off;

  always #4 clk = ~clk;

  core_rst_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .core_off(core_off), .core_start(core_start)
  );

  task automatic cmp(input string tag, input logic [39:0] exp);
    logic [39:0] act;
    act = {rd_data, core_off, core_start};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rd/off/start act=%h/%b/%b exp=%h/%b/%b", tag,
               act[39:8], act[7:4], act[3:0], exp[39:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input string tag);
    logic [31:0] nv;
    logic [3:0]  st;
    @(negedge clk);
    nv    = (d & ~RSVD) | (RSTV & RSVD);
    st    = m_reg[3:0] & ~nv[3:0];
    m_off = nv[3:0];
    m_reg = nv;
    exp_q.push_back({m_reg, m_off, st});
    tag_q.push_back(tag);
    wr_en   = 1'b1;
    wr_data = d;
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    exp_q.push_back({m_reg, m_off, 4'b0000});
    tag_q.push_back(tag);
    wr_en   = 1'b0;
    wr_data = $urandom;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) cmp(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reg = RSTV;
    m_off = 4'hf;
    repeat (3) @(posedge clk);
    #2;
    cmp("R1 reset", {RSTV, 4'b1111, 4'b0000});
    @(negedge clk);
    rst_n = 1'b1;
    do_idle("R8 idle after reset");
    do_write(32'h0000_3d0e, "R5 core0 start");
    do_idle("R8 pulse ends");
    do_write(32'h0000_3d0e, "R6 same value");
    do_write(32'h0000_3d0f, "R4 core0 off");
    do_write(32'hffff_ffff, "R2 reserved ignored");
    do_write(32'h0000_0000, "R7 all start");
    do_write(32'h0000_0005, "R7 cores 0 2 off");
    do_write(32'h0000_000a, "R7 mixed off and start");
    do_write(32'h0000_000f, "R9 back to back 1");
    do_write(32'h0000_0000, "R9 back to back 2");
    do_write(32'h0000_000f, "R9 back to back 3");
    do_write(32'h0000_c2f0, "R2 reserved only");
    do_write(32'h1234_5670, "R3 pattern store");
    do_write(32'h1234_5670, "R6 repeat pattern");
    do_write(32'ha5a5_3d0c, "R3 pattern two");
    do_idle("R8 idle hold");
    do_idle("R8 idle hold 2");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule